// File: doc/BRIEF.md
# Dual-Mode DAC Input Interface

This block is the digital front end of a high-resolution DAC. A mode pin chooses how code words come in. In serial mode, words are shifted in one bit per strobe. In byte mode, two 8-bit halves are written, each marked by its own enable. Every load happens on a rising edge of the chip-select strobe. The captured word sits in a first-rank register. A level-sensitive load control passes it on to the second-rank DAC latch, and that latch drives the converter's code input.

Serial mode takes 16-bit or 18-bit words, MSB-first or LSB-first. Some data pins change role in this mode: bit 0 becomes the serial input, bit 1 picks the bit order and bit 2 picks the word length. The first rank then works as a shift register, and a serial output passes the displaced bits on to the next device in a chain.

A clear input forces the DAC latch to zero or to midscale, and leaves the first rank as it was. A bypass input lets an external controller, such as a calibration sequencer, write the DAC latch directly. All inputs are sampled on `clk`.

Top module: `dual_dac_front`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, `dac_code` and `ser_out` are 0 and the first rank holds 0.
- R2: With `byte_mode`=0, `data_in[1]`=1 and `data_in[2]`=1, each strobe edge shifts `data_in[0]` into bit 0 of the 18-bit first rank, moving the older bits toward bit 17. After 18 edges, the first bit sent is in bit 17.
- R3: With `byte_mode`=0, `data_in[1]`=0 and `data_in[2]`=1, each edge shifts the new bit into bit 17, moving the older bits toward bit 0. After 18 edges, the first bit sent is in bit 0.
- R4: With `byte_mode`=0 and `data_in[2]`=0, a 16-bit word is shifted in the same way as in R2 and R3, but only within bits 17..2. Bits 1..0 of the first rank are forced to 0, so the word appears left-aligned in `dac_code`.
- R5: In serial mode, `ser_out` shows the bit that the next edge will push out. This is bit 17 when `data_in[1]`=1. When `data_in[1]`=0 it is bit 0 for 18-bit words and bit 2 for 16-bit words. In byte mode `ser_out` is 0.
- R6: Only a low-to-high change of `cs_strobe` between two consecutive clocks loads the first rank. Holding the strobe high loads nothing further.
- R7: In byte mode, an edge with `hi_en`=1 writes `data_in` to first-rank bits 17..10. An edge with `lo_en`=1 writes it to bits 9..2. Either order gives the same word. In serial mode `hi_en` and `lo_en` have no effect on the first rank.
- R8: While `load_en`=1, the DAC latch takes the first rank's new value in the same clock as the first rank, so the update is visible one clock after the edge. While `load_en`=0, with no clear and no bypass, `dac_code` holds.
- R9: While `clear_req`=1, the next `dac_code` is 0 if `lo_en`=0, or 0x20000 (MSB set only) if `lo_en`=1. The first rank is untouched and reappears once `load_en` is high again.
- R10: While `byp_en`=1 and `clear_req`=0, the next `dac_code` equals `byp_code`, whatever `load_en` is.
- R11: Priority on the DAC latch is clear first, then bypass, then load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_mode | input | 1 | 1 = byte loading, 0 = serial loading |
| data_in | input | 8 | Byte data; in serial mode bit 0 is data, bit 1 is the order and bit 2 is the length |
| cs_strobe | input | 1 | Load strobe; acts on its rising edge |
| hi_en | input | 1 | Byte mode: the strobe writes the upper byte |
| lo_en | input | 1 | Byte mode: the strobe writes the lower byte; also selects the clear target |
| load_en | input | 1 | Level-sensitive transparency of the DAC latch |
| clear_req | input | 1 | Forces the DAC latch to the clear target |
| byp_en | input | 1 | External control of the DAC latch |
| byp_code | input | 18 | Code written while bypass is active |
| dac_code | output | 18 | Second-rank DAC code |
| ser_out | output | 1 | Daisy-chain serial output |

## Verification
The bench shifts words through all four combinations of length and order. It checks the alignment of 16-bit words and reads a loaded word back through `ser_out`: a wrong tap point there would scramble or shorten the bits that reach the next device in a chain.

It holds the strobe high for several clocks, where a level-triggered capture would load the same bit repeatedly. It writes both halves in each order, and pulses the byte enables during serial loads, where a design that did not ignore them would corrupt the word.

It also clears to each target and then restores the first rank. A clear that reached the first rank would lose the stored word, and a wrong priority among clear, bypass and load would show the wrong code.

// File: rtl/dfe_pkg.sv
// Shared sizing and types for the dual-mode DAC front end.
// Assumes CODE_W > SHORT_W and SHORT_W == 2 * BYTE_W.
package dfe_pkg;
    parameter int CODE_W  = 18;
    parameter int SHORT_W = 16;
    parameter int BYTE_W  = 8;

    // Source the second-rank latch takes on the next clock
    typedef enum logic [1:0] {
        SRC_HOLD   = 2'd0,
        SRC_RANK1  = 2'd1,
        SRC_BYPASS = 2'd2,
        SRC_CLEAR  = 2'd3
    } r2_src_e;
endpackage

// File: rtl/dfe_strobe_det.sv
// Rising-edge detector for the load strobe.
// Assumes the strobe is already synchronous to clk.
// The previous sample resets low, so a strobe held high through reset fires once afterwards.
module dfe_strobe_det (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    output logic fire
);
    logic prev_q;

    // Remember the strobe level from the last clock
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= strobe_in;
    end

    assign fire = strobe_in & ~prev_q;
endmodule

// File: rtl/dfe_rank1.sv
// First-rank register. It loads serially (either order, long or short word)
// or by byte halves, and shows the next value so the second rank can follow it in the same clock.
// Assumes the short word sits left-aligned with PAD zero bits below it.
module dfe_rank1 #(
    parameter int CODE_W  = dfe_pkg::CODE_W,
    parameter int SHORT_W = dfe_pkg::SHORT_W,
    parameter int BYTE_W  = dfe_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              byte_mode,
    input  logic [BYTE_W-1:0] data_in,
    input  logic              hi_en,
    input  logic              lo_en,
    output logic [CODE_W-1:0] r1_next,
    output logic              ser_out
);
    localparam int PAD    = CODE_W - SHORT_W;
    localparam int HI_LSB = CODE_W - BYTE_W;
    localparam int LO_LSB = HI_LSB - BYTE_W;
    localparam logic [CODE_W-1:0] KEEP_MASK =
        ~((CODE_W'(1) << PAD) - CODE_W'(1));

    logic [CODE_W-1:0]  r1_q;
    logic [SHORT_W-1:0] win;
    logic               sin, msb_first, long_word;

    assign sin       = data_in[0];
    assign msb_first = data_in[1];
    assign long_word = data_in[2];

    // Next-state of the first rank for a strobe edge in either mode
    always_comb begin
        r1_next = r1_q;
        win     = r1_q[CODE_W-1:PAD];
        if (fire) begin
            if (!byte_mode) begin
                if (long_word) begin
                    r1_next = msb_first ? {r1_q[CODE_W-2:0], sin}
                                        : {sin, r1_q[CODE_W-1:1]};
                end else begin
                    win = msb_first ? {win[SHORT_W-2:0], sin}
                                    : {sin, win[SHORT_W-1:1]};
                    r1_next = '0;
                    r1_next[CODE_W-1:PAD] = win;
                end
            end else begin
                if (hi_en) r1_next[HI_LSB +: BYTE_W] = data_in;
                if (lo_en) r1_next[LO_LSB +: BYTE_W] = data_in;
                r1_next = r1_next & KEEP_MASK;
            end
        end
    end

    // Register the first rank
    always_ff @(posedge clk) begin
        if (!rst_n) r1_q <= '0;
        else        r1_q <= r1_next;
    end

    // Daisy tap: the bit the next shift will displace
    always_comb begin
        if (byte_mode)      ser_out = 1'b0;
        else if (msb_first) ser_out = r1_q[CODE_W-1];
        else if (long_word) ser_out = r1_q[0];
        else                ser_out = r1_q[PAD];
    end
endmodule

// File: rtl/dfe_rank2.sv
// Second-rank DAC latch: clear first, then bypass, then transparent load.
// Load follows the first rank's next value, so the update lands in the same clock as the first rank.
module dfe_rank2 #(
    parameter int CODE_W = dfe_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_req,
    input  logic              clear_mid,
    input  logic              byp_en,
    input  logic [CODE_W-1:0] byp_code,
    input  logic              load_en,
    input  logic [CODE_W-1:0] r1_next,
    output logic [CODE_W-1:0] dac_code
);
    import dfe_pkg::*;

    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

    r2_src_e src;

    // Pick the source by priority
    always_comb begin
        if (clear_req)    src = SRC_CLEAR;
        else if (byp_en)  src = SRC_BYPASS;
        else if (load_en) src = SRC_RANK1;
        else              src = SRC_HOLD;
    end

    // Update the DAC latch from the chosen source
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_code <= '0;
        end else begin
            unique case (src)
                SRC_CLEAR:  dac_code <= clear_mid ? MID_CODE : '0;
                SRC_BYPASS: dac_code <= byp_code;
                SRC_RANK1:  dac_code <= r1_next;
                default:    dac_code <= dac_code;
            endcase
        end
    end
endmodule

// File: rtl/dual_dac_front.sv
// Top of the dual-mode DAC input interface.
// Holds the strobe edge detector, the first rank (serial or byte loading) and the
// second-rank latch with clear and bypass. All controls except the strobe act on their level.
module dual_dac_front #(
    parameter int CODE_W  = dfe_pkg::CODE_W,
    parameter int SHORT_W = dfe_pkg::SHORT_W,
    parameter int BYTE_W  = dfe_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_mode,
    input  logic [BYTE_W-1:0] data_in,
    input  logic              cs_strobe,
    input  logic              hi_en,
    input  logic              lo_en,
    input  logic              load_en,
    input  logic              clear_req,
    input  logic              byp_en,
    input  logic [CODE_W-1:0] byp_code,
    output logic [CODE_W-1:0] dac_code,
    output logic              ser_out
);
    logic              fire;
    logic [CODE_W-1:0] r1_next;

    dfe_strobe_det u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_in (cs_strobe),
        .fire      (fire)
    );

    dfe_rank1 #(.CODE_W(CODE_W), .SHORT_W(SHORT_W), .BYTE_W(BYTE_W)) u_rank1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .byte_mode (byte_mode),
        .data_in   (data_in),
        .hi_en     (hi_en),
        .lo_en     (lo_en),
        .r1_next   (r1_next),
        .ser_out   (ser_out)
    );

    dfe_rank2 #(.CODE_W(CODE_W)) u_rank2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_req (clear_req),
        .clear_mid (lo_en),
        .byp_en    (byp_en),
        .byp_code  (byp_code),
        .load_en   (load_en),
        .r1_next   (r1_next),
        .dac_code  (dac_code)
    );
endmodule

// File: rtl/dfe_checker.sv
// Checker for dual_dac_front, seeing only the top-level ports.
module dfe_checker #(
    parameter int CODE_W  = dfe_pkg::CODE_W,
    parameter int SHORT_W = dfe_pkg::SHORT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_mode,
    input logic              long_sel,
    input logic              cs_strobe,
    input logic              lo_en,
    input logic              load_en,
    input logic              clear_req,
    input logic              byp_en,
    input logic [CODE_W-1:0] byp_code,
    input logic [CODE_W-1:0] dac_code,
    input logic              ser_out
);
    localparam int PAD = CODE_W - SHORT_W;
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

    logic cs_prev;

    // Own copy of the strobe history for edge-qualified checks
    always_ff @(posedge clk) begin
        if (!rst_n) cs_prev <= 1'b0;
        else        cs_prev <= cs_strobe;
    end

    // R9: clear lands on the target chosen by lo_en
    a_r9_clear_target: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> dac_code == ($past(lo_en) ? MID_CODE : '0));

    // R10: bypass without clear writes byp_code
    a_r10_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (byp_en && !clear_req) |=> dac_code == $past(byp_code));

    // R8: latch holds when nothing drives it
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_req && !byp_en && !load_en) |=> $stable(dac_code));

    // R5: no serial output in byte mode
    a_r5_byte_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        byte_mode |-> !ser_out);

    // R4: a short serial word shows zero pad bits when loaded through
    a_r4_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_mode && !long_sel && cs_strobe && !cs_prev && load_en
         && !clear_req && !byp_en) |=> dac_code[PAD-1:0] == '0);
endmodule

bind dual_dac_front dfe_checker #(.CODE_W(CODE_W), .SHORT_W(SHORT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_mode (byte_mode),
    .long_sel  (data_in[2]),
    .cs_strobe (cs_strobe),
    .lo_en     (lo_en),
    .load_en   (load_en),
    .clear_req (clear_req),
    .byp_en    (byp_en),
    .byp_code  (byp_code),
    .dac_code  (dac_code),
    .ser_out   (ser_out)
);

// File: tb/sim_dual_dac_front.sv
// Bench for dual_dac_front: a behavioural model updated on every rising clock edge
// is compared against the ports at every falling edge, and directed checks are added on top.
module sim_dual_dac_front;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        byte_mode, cs_strobe, hi_en, lo_en, load_en, clear_req, byp_en;
    logic [7:0]  data_in;
    logic [17:0] byp_code;
    logic [17:0] dac_code;
    logic        ser_out;

    int total = 0;
    int bad = 0;
    string cur_tag = "R1";

    // Model state
    int m_r1, m_dac;
    bit m_cs_prev;

    always #2.5 clk = ~clk;

    dual_dac_front u0 (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .data_in(data_in),
        .cs_strobe(cs_strobe), .hi_en(hi_en), .lo_en(lo_en), .load_en(load_en),
        .clear_req(clear_req), .byp_en(byp_en), .byp_code(byp_code),
        .dac_code(dac_code), .ser_out(ser_out)
    );

    // Behavioural model, written as arithmetic on integers
    always @(posedge clk) begin
        int n, v;
        bit edge_seen;
        edge_seen = cs_strobe && !m_cs_prev;
        if (!rst_n) begin
            m_r1 = 0; m_dac = 0; m_cs_prev = 0;
        end else begin
            m_cs_prev = cs_strobe;
            if (edge_seen) begin
                if (!byte_mode) begin
                    n = data_in[2] ? 18 : 16;
                    v = (n == 18) ? m_r1 : (m_r1 / 4);
                    if (data_in[1]) v = (v * 2 + data_in[0]) % (1 << n);
                    else            v = v / 2 + data_in[0] * (1 << (n - 1));
                    m_r1 = (n == 18) ? v : v * 4;
                end else begin
                    if (hi_en) m_r1 = (m_r1 % 1024) + data_in * 1024;
                    if (lo_en) m_r1 = (m_r1 / 1024) * 1024 + data_in * 4;
                    m_r1 = (m_r1 / 4) * 4;
                end
            end
            if (clear_req)    m_dac = lo_en ? 131072 : 0;
            else if (byp_en)  m_dac = byp_code;
            else if (load_en) m_dac = m_r1;
        end
    end

    function automatic int exp_sout();
        if (byte_mode)  return 0;
        if (data_in[1]) return (m_r1 / 131072) % 2;
        if (data_in[2]) return m_r1 % 2;
        return (m_r1 / 4) % 2;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Wait for the falling edge and compare the ports with the model
    task automatic tick();
        @(negedge clk);
        chk({cur_tag, " model dac_code"}, int'(dac_code), m_dac);
        chk({cur_tag, " model ser_out"}, int'(ser_out), exp_sout());
    endtask

    task automatic strobe();
        cs_strobe = 1'b1; tick();
        cs_strobe = 1'b0; tick();
    endtask

    // Shift one word serially and gather what ser_out showed before each edge
    task automatic shift_word(input int w, input int n, input bit msb, output int seen);
        seen = 0;
        byte_mode = 1'b0;
        data_in[7:3] = 5'b10110;
        data_in[2] = (n == 18);
        data_in[1] = msb;
        for (int i = 0; i < n; i++) begin
            data_in[0] = msb ? ((w >> (n - 1 - i)) & 1) : ((w >> i) & 1);
            #1;
            if (msb) seen = (seen << 1) | int'(ser_out);
            else     seen = seen | (int'(ser_out) << i);
            strobe();
        end
    endtask

    task automatic write_byte(input bit hi, input logic [7:0] b);
        byte_mode = 1'b1; hi_en = hi; lo_en = !hi; data_in = b;
        strobe();
        hi_en = 1'b0; lo_en = 1'b0;
        tick();
    endtask

    initial begin : watchdog
        #(200000 * 5ns);
        bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        int seen;
        rst_n = 1'b0; byte_mode = 1'b0; data_in = '0; cs_strobe = 1'b0;
        hi_en = 1'b0; lo_en = 1'b0; load_en = 1'b0; clear_req = 1'b0;
        byp_en = 1'b0; byp_code = '0;
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();
        cur_tag = "R1";
        chk("R1 reset dac_code", int'(dac_code), 0);
        chk("R1 reset ser_out", int'(ser_out), 0);

        // R2 and R7: MSB-first long word with byte enables raised (ignored), load low
        cur_tag = "R2";
        hi_en = 1'b1; lo_en = 1'b1;
        shift_word(18'h2B3C5, 18, 1'b1, seen);
        hi_en = 1'b0; lo_en = 1'b0;
        chk("R8 hold while load low", int'(dac_code), 0);
        load_en = 1'b1; tick();
        chk("R2 msb-first 18-bit", int'(dac_code), 18'h2B3C5);
        chk("R7 enables ignored in serial mode", int'(dac_code), 18'h2B3C5);

        // R3: LSB-first long word, loaded straight through
        cur_tag = "R3";
        shift_word(18'h1A5F3, 18, 1'b0, seen);
        chk("R3 lsb-first 18-bit", int'(dac_code), 18'h1A5F3);
        chk("R5 ser_out lsb 18-bit tap", int'(ser_out), 1);

        // R4: short words, both orders
        cur_tag = "R4";
        shift_word(16'h1234, 16, 1'b0, seen);
        chk("R4 lsb-first 16-bit aligned", int'(dac_code), 18'h048D0);
        shift_word(16'hBEEF, 16, 1'b1, seen);
        chk("R4 msb-first 16-bit aligned", int'(dac_code), 18'h2FBBC);

        // R5: push the short word out through the chain tap
        cur_tag = "R5";
        shift_word(0, 16, 1'b1, seen);
        chk("R5 daisy 16-bit word out", seen, 16'hBEEF);
        chk("R4 after zeros", int'(dac_code), 0);

        // R6: strobe held high captures only once
        cur_tag = "R6";
        data_in = 8'b0000_0111;
        cs_strobe = 1'b1;
        for (int i = 0; i < 5; i++) tick();
        cs_strobe = 1'b0; tick();
        chk("R6 single capture", int'(dac_code), 1);

        // R7: byte halves in both orders, serial tap quiet
        cur_tag = "R7";
        write_byte(1'b1, 8'hA5);
        write_byte(1'b0, 8'h3C);
        chk("R7 hi then lo", int'(dac_code), 18'h294F0);
        chk("R5 byte mode ser_out", int'(ser_out), 0);
        write_byte(1'b0, 8'h11);
        write_byte(1'b1, 8'h22);
        chk("R7 lo then hi", int'(dac_code), 18'h08844);

        // R9: clear to each target, then restore from the first rank
        cur_tag = "R9";
        lo_en = 1'b0; clear_req = 1'b1; tick();
        chk("R9 clear to zero", int'(dac_code), 0);
        clear_req = 1'b0; load_en = 1'b0; tick();
        chk("R8 stays cleared with load low", int'(dac_code), 0);
        lo_en = 1'b1; clear_req = 1'b1; tick();
        chk("R9 clear to midscale", int'(dac_code), 18'h20000);
        clear_req = 1'b0; lo_en = 1'b0; load_en = 1'b1; tick();
        chk("R9 first rank restored", int'(dac_code), 18'h08844);

        // R10 and R11: bypass, and the priorities
        cur_tag = "R10";
        byp_en = 1'b1; byp_code = 18'h15555; tick();
        chk("R10 bypass over load", int'(dac_code), 18'h15555);
        cur_tag = "R11";
        clear_req = 1'b1; tick();
        chk("R11 clear over bypass", int'(dac_code), 0);
        clear_req = 1'b0; byp_en = 1'b0; tick();
        chk("R11 load after bypass", int'(dac_code), 18'h08844);

        // Random traffic, compared with the model every clock
        cur_tag = "R8 R2 R7 random";
        for (int i = 0; i < 600; i++) begin
            byte_mode = ($urandom % 4) == 0;
            data_in   = 8'($urandom);
            cs_strobe = $urandom % 2;
            hi_en     = $urandom % 2;
            lo_en     = $urandom % 2;
            load_en   = ($urandom % 3) != 0;
            clear_req = ($urandom % 16) == 0;
            byp_en    = ($urandom % 12) == 0;
            byp_code  = 18'($urandom);
            tick();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule